// File: doc/BRIEF.md
# Multi-mode Register Shifter Unit

This unit shifts a 16-bit source operand left or right by a distance held in a second register. It is meant for the execute stage of a small register-based processor. A single direction bit and a 2-bit fill-mode field select the operation, so one unit covers logical shifts, shifts that fill with ones, arithmetic-style shifts that copy the end bit, and rotates. The fill mode decides what moves into the vacated bit positions.

The shift is computed combinationally by a logarithmic stage network. A single output register captures the result on the clock edge where the start strobe is high, and a valid flag goes high for the cycle after each start. Instruction decode, register-file access and status flags belong to other blocks.

Top module: `shf_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `result_o` becomes 0 and `valid_o` becomes 0.
- R2: When `start_i` is 1 at a rising edge, `result_o` takes the shifted value and `valid_o` is 1 for the following cycle. When `start_i` is 0 at an edge, `valid_o` becomes 0 and `result_o` keeps its value, whatever the other inputs do.
- R3: `dir_i` = 0 shifts toward the MSB (left) and `dir_i` = 1 shifts toward the LSB (right). With `mode_i` = 2'b00, zeros enter the vacated positions.
- R4: With `mode_i` = 2'b01, ones enter the vacated positions.
- R5: With `mode_i` = 2'b10, copies of the end bit enter the vacated positions: operand bit 0 on a left shift, operand bit 15 on a right shift.
- R6: With `mode_i` = 2'b11, bits leaving one end re-enter at the other end. Only `amount_i[3:0]` sets the rotate distance.
- R7: An `amount_i` of 0 returns the operand unchanged in all four modes and both directions.
- R8: In modes 2'b00, 2'b01 and 2'b10, any `amount_i` of 16 or more gives a result made only of fill bits: all zeros, all ones, or 16 copies of the end bit that R5 selects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Capture strobe for one operation |
| dir_i | input | 1 | 0 = left, 1 = right |
| mode_i | input | 2 | Fill mode: 00 zero, 01 one, 10 end-bit copy, 11 rotate |
| operand_i | input | 16 | Value to shift |
| amount_i | input | 16 | Shift distance, taken from a register |
| result_o | output | 16 | Registered shifted value |
| valid_o | output | 1 | High for one cycle after each start |

## Verification
The bench sweeps every direction and fill mode. It uses every distance from 0 to 20 and several large distances whose low four bits are not zero. It runs each of these on operands chosen so that their end bits differ. A design that tested only the low four bits for saturation would wrap a distance of 17 into a shift of 1 instead of returning all fill bits. A design that used the wrong end bit in copy mode would sign-fill left shifts. The bench also checks that a rotate ignores the upper distance bits, and that the result holds while inputs change with no start, which catches a result register that loads on every cycle.

// File: rtl/shf_pkg.sv
// Package: shared encodings for the shifter unit.
// Assumes: the data width is a power of two.
package shf_pkg;

    // Fill-mode field encodings; the values are fixed by the instruction format.
    typedef enum logic [1:0] {
        FILL_ZERO = 2'b00,
        FILL_ONE  = 2'b01,
        FILL_EDGE = 2'b10,
        FILL_ROT  = 2'b11
    } fill_mode_e;

    // Direction bit encoding.
    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } shift_dir_e;

endpackage

// File: rtl/shf_stage.sv
// Module: shf_stage
// One fixed-distance step of the logarithmic shifter. When en_i is set it
// moves the word by SHIFT places in the chosen direction and fills the
// vacated places according to the fill mode; otherwise it passes data through.
// Assumes: 0 < SHIFT < WIDTH. In edge-copy mode the end bit of the incoming
// word is still the original end bit, because earlier stages preserve it.
module shf_stage
    import shf_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int SHIFT = 1
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic             en_i,
    input  shift_dir_e       dir_i,
    input  fill_mode_e       mode_i,
    output logic [WIDTH-1:0] data_o
);

    logic             fill_bit;
    logic [SHIFT-1:0] fill_vec;
    logic [WIDTH-1:0] moved;

    // Pick the single bit used by the non-rotate modes.
    always_comb begin
        unique case (mode_i)
            FILL_ONE:  fill_bit = 1'b1;
            FILL_EDGE: fill_bit = (dir_i == DIR_RIGHT) ? data_i[WIDTH-1] : data_i[0];
            default:   fill_bit = 1'b0;
        endcase
    end

    // Build the bits that enter the vacated places (wrapped bits for rotate).
    always_comb begin
        if (mode_i == FILL_ROT) begin
            fill_vec = (dir_i == DIR_RIGHT) ? data_i[SHIFT-1:0]
                                            : data_i[WIDTH-1:WIDTH-SHIFT];
        end else begin
            fill_vec = {SHIFT{fill_bit}};
        end
    end

    // Move the word by SHIFT places and splice in the fill bits.
    always_comb begin
        if (dir_i == DIR_RIGHT) begin
            moved = {fill_vec, data_i[WIDTH-1:SHIFT]};
        end else begin
            moved = {data_i[WIDTH-1-SHIFT:0], fill_vec};
        end
    end

    // Bypass the step when this bit of the distance is clear.
    always_comb begin
        data_o = en_i ? moved : data_i;
    end

endmodule

// File: rtl/shf_barrel.sv
// Module: shf_barrel
// Chain of log2(WIDTH) shf_stage instances. Stage k moves by 2**k when bit k
// of the distance is set, so any distance below WIDTH finishes in one pass.
// Assumes: WIDTH is a power of two; distances of WIDTH or more are handled
// by shf_range in the parent.
module shf_barrel
    import shf_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] operand_i,
    input  logic [SHW-1:0]   dist_i,
    input  shift_dir_e       dir_i,
    input  fill_mode_e       mode_i,
    output logic [WIDTH-1:0] result_o
);

    logic [WIDTH-1:0] lvl [0:SHW];

    // The first level is the unshifted operand.
    always_comb begin
        lvl[0] = operand_i;
    end

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        shf_stage #(
            .WIDTH (WIDTH),
            .SHIFT (1 << k)
        ) u_stage (
            .data_i (lvl[k]),
            .en_i   (dist_i[k]),
            .dir_i  (dir_i),
            .mode_i (mode_i),
            .data_o (lvl[k+1])
        );
    end

    // The last level is the shifted result.
    always_comb begin
        result_o = lvl[SHW];
    end

endmodule

// File: rtl/shf_range.sv
// Module: shf_range
// Detects a distance of WIDTH or more for the non-rotate modes and supplies
// the word made only of fill bits that replaces the stage output in that case.
// Assumes: WIDTH is a power of two and AMT_W > log2(WIDTH).
module shf_range
    import shf_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int AMT_W = 16,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] operand_i,
    input  logic [AMT_W-1:0] amount_i,
    input  shift_dir_e       dir_i,
    input  fill_mode_e       mode_i,
    output logic             over_o,
    output logic [WIDTH-1:0] fill_word_o
);

    logic high_set;

    // Any set bit above the stage range means the distance is WIDTH or more.
    always_comb begin
        high_set = |amount_i[AMT_W-1:SHW];
    end

    // A rotate wraps instead of saturating, so only the fill modes report overflow.
    always_comb begin
        over_o = high_set && (mode_i != FILL_ROT);
    end

    // Form the all-fill word for the current mode and direction.
    always_comb begin
        unique case (mode_i)
            FILL_ONE:  fill_word_o = '1;
            FILL_EDGE: fill_word_o = {WIDTH{(dir_i == DIR_RIGHT) ? operand_i[WIDTH-1]
                                                                 : operand_i[0]}};
            default:   fill_word_o = '0;
        endcase
    end

endmodule

// File: rtl/shf_outreg.sv
// Module: shf_outreg
// Output stage: loads the result on a start strobe and raises valid for the
// cycle after it. Holds the previous result when no start is seen.
// Assumes: synchronous active-low reset.
module shf_outreg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] data_o,
    output logic             valid_o
);

    // Capture the result and flag it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= load_i;
            if (load_i) begin
                data_o <= data_i;
            end
        end
    end

endmodule

// File: rtl/shf_unit.sv
// Module: shf_unit
// Top of the multi-mode shifter. It combines the stage network, the
// out-of-range override and the output register. The result appears one
// cycle after start_i, together with a one-cycle valid pulse.
// Assumes: WIDTH is a power of two; amount_i comes from a register.
module shf_unit
    import shf_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int AMT_W = 16,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             dir_i,
    input  logic [1:0]       mode_i,
    input  logic [WIDTH-1:0] operand_i,
    input  logic [AMT_W-1:0] amount_i,
    output logic [WIDTH-1:0] result_o,
    output logic             valid_o
);

    fill_mode_e       mode_e;
    shift_dir_e       dir_e;
    logic [WIDTH-1:0] barrel_q;
    logic [WIDTH-1:0] fill_word;
    logic             over;
    logic [WIDTH-1:0] next_result;

    // Map the raw control pins onto the shared encodings.
    always_comb begin
        mode_e = fill_mode_e'(mode_i);
        dir_e  = shift_dir_e'(dir_i);
    end

    shf_barrel #(
        .WIDTH (WIDTH)
    ) u_barrel (
        .operand_i (operand_i),
        .dist_i    (amount_i[SHW-1:0]),
        .dir_i     (dir_e),
        .mode_i    (mode_e),
        .result_o  (barrel_q)
    );

    shf_range #(
        .WIDTH (WIDTH),
        .AMT_W (AMT_W)
    ) u_range (
        .operand_i   (operand_i),
        .amount_i    (amount_i),
        .dir_i       (dir_e),
        .mode_i      (mode_e),
        .over_o      (over),
        .fill_word_o (fill_word)
    );

    // Choose the saturated fill word for out-of-range distances.
    always_comb begin
        next_result = over ? fill_word : barrel_q;
    end

    shf_outreg #(
        .WIDTH (WIDTH)
    ) u_outreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (start_i),
        .data_i  (next_result),
        .data_o  (result_o),
        .valid_o (valid_o)
    );

    AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o); // R2
    AST_VALID_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !valid_o); // R2
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(result_o)); // R2
    AST_ZERO_DIST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && amount_i == '0) |=> result_o == $past(operand_i)); // R7
    AST_ROT_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && mode_i == 2'b11) |=> $countones(result_o) == $countones($past(operand_i))); // R6
    AST_SAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && mode_i == 2'b00 && amount_i >= AMT_W'(WIDTH)) |=> result_o == '0); // R8
    AST_SAT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && mode_i == 2'b01 && amount_i >= AMT_W'(WIDTH)) |=> result_o == '1); // R8
    AST_ZERO_FILL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && mode_i == 2'b00) |=> $countones(result_o) <= $countones($past(operand_i))); // R3
    AST_ONE_FILL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && mode_i == 2'b01) |=> $countones(result_o) >= $countones($past(operand_i))); // R4

endmodule

// File: tb/shf_unit_tb.sv
// Bench: sweeps direction, fill mode, distance and operand, and compares
// against a bit-by-bit reference computed from the requirements.
module shf_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int AW         = 16;
    localparam int WATCHDOG   = 150000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start_i;
    logic          dir_i;
    logic [1:0]    mode_i;
    logic [W-1:0]  operand_i;
    logic [AW-1:0] amount_i;
    logic [W-1:0]  result_o;
    logic          valid_o;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    shf_unit #(.WIDTH(W), .AMT_W(AW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .dir_i     (dir_i),
        .mode_i    (mode_i),
        .operand_i (operand_i),
        .amount_i  (amount_i),
        .result_o  (result_o),
        .valid_o   (valid_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference result from the requirements, one output bit at a time.
    function automatic logic [W-1:0] ref_shift(input logic d, input logic [1:0] m,
                                               input logic [W-1:0] op, input logic [AW-1:0] amt);
        logic [W-1:0] r;
        logic         fb;
        int           a;
        fb = (m == 2'b01) ? 1'b1 : (m == 2'b10) ? (d ? op[W-1] : op[0]) : 1'b0;
        for (int i = 0; i < W; i++) begin
            if (m == 2'b11) begin
                a = int'(amt[3:0]);
                r[i] = d ? op[(i + a) % W] : op[(i - a + W) % W];
            end else if (amt >= AW'(W)) begin
                r[i] = fb;
            end else begin
                a = int'(amt);
                if (d) r[i] = (i + a < W) ? op[i + a] : fb;
                else   r[i] = (i - a >= 0) ? op[i - a] : fb;
            end
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [W-1:0]  ops  [8];
        logic [AW-1:0] bigs [4];
        logic [W-1:0]  held;
        string         tag;
        ops[0] = 16'h0001; ops[1] = 16'h8000; ops[2] = 16'hA5C3; ops[3] = 16'h5A3C;
        ops[4] = 16'hFFFF; ops[5] = 16'h0000; ops[6] = 16'h8001; ops[7] = 16'h7FFE;
        bigs[0] = 16'h0011; bigs[1] = 16'h0105; bigs[2] = 16'hFFFF; bigs[3] = 16'h8003;

        rst_n = 1'b0; start_i = 1'b1; dir_i = 1'b0; mode_i = 2'b01;
        operand_i = 16'hFFFF; amount_i = '0;
        repeat (3) @(negedge clk);
        check("R1 result after reset", result_o, '0);
        check("R1 valid after reset", W'(valid_o), '0);
        start_i = 1'b0;
        rst_n   = 1'b1;
        @(negedge clk);
        check("R2 valid idle", W'(valid_o), '0);

        for (int d = 0; d < 2; d++) begin
            for (int m = 0; m < 4; m++) begin
                for (int o = 0; o < 8; o++) begin
                    for (int k = 0; k < 25; k++) begin
                        dir_i     = 1'(d);
                        mode_i    = 2'(m);
                        operand_i = ops[o];
                        amount_i  = (k < 21) ? AW'(k) : bigs[k-21];
                        start_i   = 1'b1;
                        @(negedge clk);
                        if (amount_i == '0)       tag = "R7 zero distance";
                        else if (m == 3)          tag = "R6 rotate";
                        else if (amount_i >= 16)  tag = "R8 saturate";
                        else if (m == 0)          tag = "R3 zero fill";
                        else if (m == 1)          tag = "R4 one fill";
                        else                      tag = "R5 end copy";
                        check(tag, result_o, ref_shift(1'(d), 2'(m), ops[o], amount_i));
                        check("R2 valid after start", W'(valid_o), W'(1));
                    end
                end
            end
        end

        // No start: valid drops and the result holds while inputs change.
        held = result_o;
        start_i = 1'b0;
        for (int j = 0; j < 4; j++) begin
            operand_i = ops[j]; amount_i = AW'(j + 1); mode_i = 2'(j); dir_i = 1'(j);
            @(negedge clk);
            check("R2 valid low without start", W'(valid_o), '0);
            check("R2 result held", result_o, held);
        end

        // Single isolated pulse.
        operand_i = 16'h1234; amount_i = 16'd4; mode_i = 2'b11; dir_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R6 rotate left by 4", result_o, 16'h2341);
        check("R2 pulse high", W'(valid_o), W'(1));
        @(negedge clk);
        check("R2 pulse one cycle", W'(valid_o), '0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule